// File: doc/BRIEF.md
# Key-Locked Configuration Register Port

This block is the configuration front end of a four-channel UART bridge. A host reaches it over two byte-wide I/O locations: an index location that names a register and a data location that reads or writes the named register. Access is closed until the host writes an unlock key to the index location twice in succession. A separate exit key written to the same location closes access again.

Inside, the block holds read-only identification bytes and a channel selector. It also holds a bank of four RS485 control registers, one per UART channel, and the selector picks which of the four the data location reaches. Each channel's stored RS485 control nibble is driven out continuously on its own output vector, so that channel's transmitter and line driver logic can use it. The bus is a plain synchronous strobe interface. It has no back-pressure: a strobe is always accepted in the cycle it is presented, and read data comes back exactly one cycle later.

Top module: `keylock_cfg_port`

## Requirements
- R1: After reset the port is locked, the channel selector is 0, every channel control output is 4'b0000 and `bus_rvalid` is low.
- R2: Access opens only when the index location (address 0x4E) receives 0x77 on two consecutive index-location writes. Any other value written there while access is closed drops the sequence back to its start.
- R3: While open, writing 0xAA to the index location closes access. Any other value written there while open becomes the current register index.
- R4: While closed, a read of the data location (address 0x4F) returns 0xFF, and data-location writes change no register or output.
- R5: Identification indexes read fixed values: 0x20 gives 0x02, 0x21 gives 0x16, 0x23 gives 0x19 and 0x24 gives 0x34. Writes to these indexes have no effect.
- R6: Index 0x07 is the channel selector. A write of 0 to 3 is stored and reads back zero-extended. A write of a larger value is ignored.
- R7: Index 0xF0 reaches the RS485 control register of the selected channel. Only data bits 5 to 2 are stored, and a read returns those bits in place with all other bits 0.
- R8: Each channel output vector carries its own register. Vector bit 3 is data bit 5 (RTS inversion), bit 2 is data bit 4 (direction control enable), bit 1 is data bit 3 (receive wait-for-character) and bit 0 is data bit 2 (transmit wait-for-character). A write changes only the selected channel's vector.
- R9: Any index without a defined register reads 0x00, and writes to it have no effect.
- R10: A read strobe gives `bus_rvalid` high with `bus_rdata` valid on the next cycle only. A read of any address other than the data location returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | I/O address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| ch0_mode | output | 4 | RS485 control of channel 0 |
| ch1_mode | output | 4 | RS485 control of channel 1 |
| ch2_mode | output | 4 | RS485 control of channel 2 |
| ch3_mode | output | 4 | RS485 control of channel 3 |

## Verification
The bench interrupts the key sequence with a stray index value. A design that counted keys without clearing the count would open on a later single key. It writes RS485 and identification registers while access is closed or after the exit key. A leaky write gate would show up as a changed channel vector or as a read that does not return the fixed value. It selects an out-of-range channel, and a design that truncated the value would steer the next control write to the wrong channel's output. It also loads a different pattern into each channel, so a swapped bit order or a broadcast write shows on the outputs.

// File: rtl/keylock_cfg_port_pkg.sv
package keylock_cfg_port_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h77;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] IX_CHSEL  = 8'h07;
  localparam logic [7:0] IX_DEVHI  = 8'h20;
  localparam logic [7:0] IX_DEVLO  = 8'h21;
  localparam logic [7:0] IX_MFRHI  = 8'h23;
  localparam logic [7:0] IX_MFRLO  = 8'h24;
  localparam logic [7:0] IX_LINE   = 8'hF0;

  localparam logic [7:0] VAL_DEVHI = 8'h02;
  localparam logic [7:0] VAL_DEVLO = 8'h16;
  localparam logic [7:0] VAL_MFRHI = 8'h19;
  localparam logic [7:0] VAL_MFRLO = 8'h34;

  localparam logic [7:0] CLOSED_RD = 8'hFF;

  // control field sits in data bits [MODE_LSB +: MODE_W]
  localparam int MODE_W   = 4;
  localparam int MODE_LSB = 2;

  typedef enum logic [1:0] {
    GATE_SHUT  = 2'd0,
    GATE_ARMED = 2'd1,
    GATE_OPEN  = 2'd2
  } gate_t;
endpackage

// File: rtl/keylock_cfg_keyseq.sv
module keylock_cfg_keyseq
  import keylock_cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_we,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic       idx_load
);
  gate_t state, state_nx;

  always_comb begin
    state_nx = state;
    idx_load = 1'b0;
    if (idx_we) begin
      unique case (state)
        GATE_SHUT:  state_nx = (wdata == KEY_OPEN) ? GATE_ARMED : GATE_SHUT;
        GATE_ARMED: state_nx = (wdata == KEY_OPEN) ? GATE_OPEN  : GATE_SHUT;
        GATE_OPEN: begin
          if (wdata == KEY_CLOSE) state_nx = GATE_SHUT;
          else                    idx_load = 1'b1;
        end
        default: state_nx = GATE_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= GATE_SHUT;
    else        state <= state_nx;
  end

  assign open_o = (state == GATE_OPEN);
endmodule

// File: rtl/keylock_cfg_bank.sv
module keylock_cfg_bank
  import keylock_cfg_port_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_we,
  input  logic                     mode_we,
  input  logic [7:0]               wdata,
  output logic [SEL_W-1:0]         sel_q,
  output logic [NUM_CH*MODE_W-1:0] mode_q
);
  logic sel_ok;
  assign sel_ok = (wdata < 8'(NUM_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sel_q <= '0;
    else if (sel_we && sel_ok) sel_q <= wdata[SEL_W-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = mode_we && (sel_q == SEL_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mode_q[c*MODE_W +: MODE_W] <= '0;
      else if (hit) mode_q[c*MODE_W +: MODE_W] <= wdata[MODE_LSB +: MODE_W];
    end
  end
endmodule

// File: rtl/keylock_cfg_port.sv
module keylock_cfg_port
  import keylock_cfg_port_pkg::*;
#(
  parameter logic [7:0] IDX_ADDR  = 8'h4E,
  parameter logic [7:0] DATA_ADDR = 8'h4F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  output logic       bus_rvalid,
  output logic [3:0] ch0_mode,
  output logic [3:0] ch1_mode,
  output logic [3:0] ch2_mode,
  output logic [3:0] ch3_mode
);
  localparam int NUM_CH = 4;
  localparam int SEL_W  = $clog2(NUM_CH);

  logic                     unlocked;
  logic                     idx_load;
  logic [7:0]               index_q;
  logic [SEL_W-1:0]         sel_q;
  logic [NUM_CH*MODE_W-1:0] mode_q;
  logic                     data_we;
  logic [7:0]               reg_val;
  logic [MODE_W-1:0]        cur_mode;

  keylock_cfg_keyseq u_keyseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (bus_wr && (bus_addr == IDX_ADDR)),
    .wdata    (bus_wdata),
    .open_o   (unlocked),
    .idx_load (idx_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        index_q <= '0;
    else if (idx_load) index_q <= bus_wdata;
  end

  assign data_we = unlocked && bus_wr && (bus_addr == DATA_ADDR);

  keylock_cfg_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_we  (data_we && (index_q == IX_CHSEL)),
    .mode_we (data_we && (index_q == IX_LINE)),
    .wdata   (bus_wdata),
    .sel_q   (sel_q),
    .mode_q  (mode_q)
  );

  assign cur_mode = mode_q[sel_q*MODE_W +: MODE_W];

  always_comb begin
    unique case (index_q)
      IX_CHSEL: reg_val = 8'(sel_q);
      IX_DEVHI: reg_val = VAL_DEVHI;
      IX_DEVLO: reg_val = VAL_DEVLO;
      IX_MFRHI: reg_val = VAL_MFRHI;
      IX_MFRLO: reg_val = VAL_MFRLO;
      IX_LINE:  reg_val = 8'(cur_mode) << MODE_LSB;
      default:  reg_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (bus_addr != DATA_ADDR) bus_rdata <= 8'h00;
        else if (unlocked)         bus_rdata <= reg_val;
        else                       bus_rdata <= CLOSED_RD;
      end
    end
  end

  assign ch0_mode = mode_q[0*MODE_W +: MODE_W];
  assign ch1_mode = mode_q[1*MODE_W +: MODE_W];
  assign ch2_mode = mode_q[2*MODE_W +: MODE_W];
  assign ch3_mode = mode_q[3*MODE_W +: MODE_W];
endmodule

// File: rtl/keylock_cfg_port_chk.sv
module keylock_cfg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       bus_rvalid,
  input logic [3:0] ch0_mode,
  input logic [3:0] ch1_mode,
  input logic [3:0] ch2_mode,
  input logic [3:0] ch3_mode,
  input logic       unlocked
);
  logic [15:0] all_modes;
  assign all_modes = {ch3_mode, ch2_mode, ch1_mode, ch0_mode};

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_wr && bus_addr == 8'h4E && bus_wdata == 8'h77));

  // R3
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && bus_wr && bus_addr == 8'h4E && bus_wdata == 8'hAA) |=> !unlocked);

  // R4
  shut_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(all_modes));

  // R4
  shut_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h4F && !unlocked) |=> (bus_rdata == 8'hFF));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 8'h4F) |=> $stable(all_modes));

  // R8
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones({ch3_mode != $past(ch3_mode), ch2_mode != $past(ch2_mode),
                          ch1_mode != $past(ch1_mode), ch0_mode != $past(ch0_mode)}) <= 1));

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind keylock_cfg_port keylock_cfg_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .ch0_mode   (ch0_mode),
  .ch1_mode   (ch1_mode),
  .ch2_mode   (ch2_mode),
  .ch3_mode   (ch3_mode),
  .unlocked   (unlocked)
);

// File: tb/keylock_cfg_port_tb.sv
`timescale 1ns/1ps
module keylock_cfg_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic [3:0] ch0_mode, ch1_mode, ch2_mode, ch3_mode;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keylock_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ch0_mode(ch0_mode), .ch1_mode(ch1_mode), .ch2_mode(ch2_mode), .ch3_mode(ch3_mode)
  );

  // behavioural reference model
  int         m_gate;      // 0 closed, 1 one key seen, 2 open
  int         m_index;
  int         m_sel;
  int         m_mode [4];
  bit         m_rvalid;
  int         m_rdata;

  function automatic int model_reg();
    case (m_index)
      'h07: return m_sel;
      'h20: return 'h02;
      'h21: return 'h16;
      'h23: return 'h19;
      'h24: return 'h34;
      'hF0: return m_mode[m_sel] * 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gate = 0; m_index = 0; m_sel = 0; m_rvalid = 0; m_rdata = 0;
      for (int i = 0; i < 4; i++) m_mode[i] = 0;
    end else begin
      m_rvalid = bus_rd;
      if (bus_rd) begin
        if (bus_addr != 8'h4F) m_rdata = 0;
        else if (m_gate == 2)  m_rdata = model_reg();
        else                   m_rdata = 'hFF;
      end
      if (bus_wr && bus_addr == 8'h4F && m_gate == 2) begin
        if (m_index == 'h07 && bus_wdata < 4) m_sel = bus_wdata;
        if (m_index == 'hF0) m_mode[m_sel] = (bus_wdata >> 2) & 'hF;
      end
      if (bus_wr && bus_addr == 8'h4E) begin
        if (m_gate == 2) begin
          if (bus_wdata == 8'hAA) m_gate = 0;
          else m_index = bus_wdata;
        end else if (bus_wdata == 8'h77) m_gate = m_gate + 1;
        else m_gate = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(bus_rvalid == m_rvalid, "R10 rvalid", bus_rvalid, m_rvalid);
      if (m_rvalid) check(bus_rdata == m_rdata[7:0], "R10 rdata", bus_rdata, m_rdata);
      check(ch0_mode == m_mode[0][3:0], "R8 ch0", ch0_mode, m_mode[0]);
      check(ch1_mode == m_mode[1][3:0], "R8 ch1", ch1_mode, m_mode[1]);
      check(ch2_mode == m_mode[2][3:0], "R8 ch2", ch2_mode, m_mode[2]);
      check(ch3_mode == m_mode[3][3:0], "R8 ch3", ch3_mode, m_mode[3]);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check(bus_rvalid === 1'b1, req, bus_rvalid, 1);
    check(bus_rdata === exp, req, bus_rdata, exp);
    @(negedge clk);
    check(bus_rvalid === 1'b0, "R10 single pulse", bus_rvalid, 0);
  endtask

  task automatic reg_rd(input logic [7:0] ix, input logic [7:0] exp, input string req);
    wr(8'h4E, ix);
    rd_chk(8'h4F, exp, req);
  endtask

  task automatic modes_chk(input logic [15:0] exp, input string req);
    @(negedge clk);
    check({ch3_mode, ch2_mode, ch1_mode, ch0_mode} === exp, req,
          {ch3_mode, ch2_mode, ch1_mode, ch0_mode}, exp);
  endtask

  task automatic unlock();
    wr(8'h4E, 8'h77);
    wr(8'h4E, 8'h77);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(bus_rvalid === 1'b0, "R1 rvalid", bus_rvalid, 0);
    modes_chk(16'h0000, "R1 modes");
    rd_chk(8'h4F, 8'hFF, "R1 closed at reset");

    // R4 closed: writes ignored
    wr(8'h4E, 8'hF0);
    wr(8'h4F, 8'h3C);
    modes_chk(16'h0000, "R4 write while closed");
    rd_chk(8'h4F, 8'hFF, "R4 read while closed");

    // R2 interrupted sequence
    wr(8'h4E, 8'h77);
    wr(8'h4E, 8'h12);
    wr(8'h4E, 8'h77);
    rd_chk(8'h4F, 8'hFF, "R2 interrupted key stays closed");
    wr(8'h4E, 8'h77);   // completes second consecutive key -> open
    reg_rd(8'h20, 8'h02, "R2 opens after two keys");

    // R5 identification
    reg_rd(8'h21, 8'h16, "R5 id 0x21");
    reg_rd(8'h23, 8'h19, "R5 id 0x23");
    reg_rd(8'h24, 8'h34, "R5 id 0x24");
    wr(8'h4F, 8'h55);
    rd_chk(8'h4F, 8'h34, "R5 id write ignored");

    // R9 undefined index
    wr(8'h4E, 8'h55);
    wr(8'h4F, 8'hAB);
    rd_chk(8'h4F, 8'h00, "R9 undefined index");

    // R6 channel selector
    wr(8'h4E, 8'h07);
    wr(8'h4F, 8'h02);
    rd_chk(8'h4F, 8'h02, "R6 select 2");
    wr(8'h4F, 8'h05);
    rd_chk(8'h4F, 8'h02, "R6 out of range ignored");

    // R7 and R8 per-channel control
    wr(8'h4E, 8'hF0);
    wr(8'h4F, 8'hFF);
    rd_chk(8'h4F, 8'h3C, "R7 only bits 5..2 kept");
    modes_chk(16'h0F00, "R8 channel 2 only");
    wr(8'h4E, 8'h07); wr(8'h4F, 8'h00);
    wr(8'h4E, 8'hF0); wr(8'h4F, 8'h04);
    wr(8'h4E, 8'h07); wr(8'h4F, 8'h01);
    wr(8'h4E, 8'hF0); wr(8'h4F, 8'h20);
    wr(8'h4E, 8'h07); wr(8'h4F, 8'h03);
    wr(8'h4E, 8'hF0); wr(8'h4F, 8'h18);
    modes_chk(16'h6F81, "R8 bit mapping per channel");
    rd_chk(8'h4F, 8'h18, "R7 read selected channel");

    // R10 non-data address
    rd_chk(8'h4E, 8'h00, "R10 index location reads zero");

    // R3 close key
    wr(8'h4E, 8'hAA);
    rd_chk(8'h4F, 8'hFF, "R3 closed after exit key");
    wr(8'h4F, 8'h00);
    modes_chk(16'h6F81, "R3 write after close ignored");

    // reopen: state kept
    unlock();
    reg_rd(8'h07, 8'h03, "R6 selector kept across close");
    wr(8'h4E, 8'h77);   // while open a key byte is just an index
    rd_chk(8'h4F, 8'h00, "R3 key byte while open is an index");
    reg_rd(8'hF0, 8'h18, "R7 register kept");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule